// File: doc/BRIEF.md
# Contactless Memory Tag Command Engine

This block is the command-handling core of a simple proximity memory tag of the ISO 14443 type B family. An outside decoder hands it each received reader frame as a stream of bytes, followed by an end-of-frame strobe and a flag that says whether the frame check sequence was correct. The block decides what the frame means in the tag's current state, updates that state, and streams the response bytes, with a CRC_B trailer, to an outside encoder.

The tag moves through three states: ready, inventory and selected. An initiate command draws a fresh chip identifier from a free-running LFSR and enters inventory. A select carrying that identifier enters selected, where the reader may fetch the 64-bit UID and read the sixteen data blocks and one system block. A reader that restarts with an initiate while the tag is selected forces a return through the initiate path, and those restarts are counted. When the decoder delivers only the two trailing CRC bytes of an initiate, the block rebuilds the complete command. Field loss arrives on a reset-like input that a separate option input can mask.

Top module: `tag_cmd_fsm`

## Requirements
- R1: After reset the tag state is READY (encoded 0 on `tag_state`; INVENTORY is 1, SELECTED is 2), `reset_count` is 0 and `tx_valid` is low.
- R2: A 4-byte frame with good CRC whose first two bytes are 0x06 0x00 (initiate) moves a READY or INVENTORY tag to INVENTORY and is answered with one nonzero chip ID byte followed by CRC.
- R3: In INVENTORY, a 4-byte frame with good CRC starting 0x0E whose second byte equals the current chip ID moves the tag to SELECTED and is answered with that chip ID plus CRC; any other chip ID gets no reply and leaves the state unchanged.
- R4: In SELECTED, a 3-byte frame with good CRC starting 0x0B is answered with the 8 UID bytes, least significant byte first, plus CRC, and clears `reset_count` to 0.
- R5: In SELECTED, a 4-byte frame with good CRC starting 0x08 with address byte A is answered with 4 data bytes plus CRC: for A in 0..15 byte k (k = 0 first) is 16*A + k; for A = 255 the bytes are the system word, least significant first; any other A gets no reply.
- R6: An initiate received in SELECTED increments `reset_count` (saturating at its all-ones value), then is served as a fresh initiate: state INVENTORY and a chip ID reply.
- R7: A frame of exactly the two bytes 0x97 0x5B is served as the complete initiate 0x06 0x00 0x97 0x5B, even when the CRC flag is low; other two-byte frames get no reply.
- R8: A frame with the CRC flag low, an unknown opcode, or a command not accepted in the current state gets no reply and leaves state and `reset_count` unchanged.
- R9: With `field_ignore` low, a `field_lost` pulse returns the tag to READY in the next cycle without a reply; with `field_ignore` high, `field_lost` has no effect.
- R10: The first response byte is on `tx_data` with `tx_valid` high two clock cycles after the cycle carrying `rx_eof`; the bytes follow on consecutive cycles and `tx_last` marks only the final CRC byte.
- R11: The response CRC is CRC_B (preset 0xFFFF, reflected polynomial 0x8408, final inversion) over the payload bytes, sent low byte first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End of the received frame |
| rx_crc_ok | input | 1 | Frame check result, valid with `rx_eof` |
| field_lost | input | 1 | Carrier loss indication |
| field_ignore | input | 1 | Masks `field_lost` when high |
| tx_valid | output | 1 | A response byte is on `tx_data` |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Final byte of the response |
| tag_state | output | 2 | Current state: 0 ready, 1 inventory, 2 selected |
| reset_count | output | CNT_W | Consecutive initiates received while selected |

## Verification
Every result has a fixed due cycle: the frame collector registers the frame at the edge that samples `rx_eof`, and the state register and the serializer load together on the following edge, so state and the first response byte are both due two cycles after the end-of-frame cycle, with one byte per cycle after that. The bench drives on falling edges and, two falling edges after raising `rx_eof`, requires the first byte to be present and then gathers bytes on every following falling edge until `tx_valid` drops, so a late or early reply shows as a length or content mismatch. State and counter are read at that same falling edge, and a `field_lost` pulse is judged one falling edge after it is driven.

// File: rtl/tag_pkg.sv
package tag_pkg;

   typedef enum logic [1:0] {
      ST_READY     = 2'd0,
      ST_INVENTORY = 2'd1,
      ST_SELECTED  = 2'd2
   } tag_state_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_DROP,
      ACT_INIT,
      ACT_SEL,
      ACT_UID,
      ACT_READ
   } tag_act_e;

   localparam logic [7:0] OP_INIT  = 8'h06;
   localparam logic [7:0] OP_SEL   = 8'h0E;
   localparam logic [7:0] OP_UID   = 8'h0B;
   localparam logic [7:0] OP_READ  = 8'h08;
   localparam logic [7:0] INIT_ARG = 8'h00;

   // trailing bytes of an initiate frame with a zero argument
   localparam logic [7:0] CUT_B0 = 8'h97;
   localparam logic [7:0] CUT_B1 = 8'h5B;

   // one byte of CRC_B, shifted LSB first
   function automatic logic [15:0] crcb_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c ^ {8'h00, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/tag_rx_frame.sv
module tag_rx_frame #(
   parameter int MAX_RX = 6,
   parameter int LEN_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eof,
   input  logic             rx_crc_ok,
   output logic             fr_valid,
   output logic             fr_crc_ok,
   output logic [LEN_W-1:0] fr_len,
   output logic [7:0]       fr_b0,
   output logic [7:0]       fr_b1
);
   import tag_pkg::*;

   localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_RX + 1);

   logic [LEN_W-1:0] cnt;
   logic [7:0]       h0, h1;
   logic             cut_init;

   // a two-byte frame holding only the initiate trailer
   assign cut_init = (cnt == LEN_W'(2)) && (h0 == CUT_B0) && (h1 == CUT_B1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         h0        <= '0;
         h1        <= '0;
         fr_valid  <= 1'b0;
         fr_crc_ok <= 1'b0;
         fr_len    <= '0;
         fr_b0     <= '0;
         fr_b1     <= '0;
      end else begin
         fr_valid <= 1'b0;
         if (rx_eof) begin
            fr_valid <= 1'b1;
            cnt      <= '0;
            if (cut_init) begin
               fr_len    <= LEN_W'(4);
               fr_b0     <= OP_INIT;
               fr_b1     <= INIT_ARG;
               fr_crc_ok <= 1'b1;
            end else begin
               fr_len    <= cnt;
               fr_b0     <= h0;
               fr_b1     <= h1;
               fr_crc_ok <= rx_crc_ok;
            end
         end else if (rx_valid) begin
            if (cnt == LEN_W'(0)) h0 <= rx_data;
            if (cnt == LEN_W'(1)) h1 <= rx_data;
            if (cnt != LEN_SAT) cnt <= cnt + LEN_W'(1);
         end
      end
   end

endmodule

// File: rtl/tag_tx_ser.sv
module tag_tx_ser #(
   parameter int TX_MAX = 8,
   parameter int LEN_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [LEN_W-1:0]      ld_len,
   input  logic [8*TX_MAX-1:0]   ld_bytes,
   output logic                  tx_valid,
   output logic [7:0]            tx_data,
   output logic                  tx_last
);
   import tag_pkg::*;

   logic [8*TX_MAX-1:0] pay;
   logic [LEN_W-1:0]    len, idx;
   logic [15:0]         crc;
   logic                busy;
   logic [7:0]          pbyte;
   logic [15:0]         crc_out;

   always_comb begin
      pbyte = '0;
      for (int i = 0; i < TX_MAX; i++) begin
         if (idx == LEN_W'(i)) pbyte = pay[8*i +: 8];
      end
   end

   assign crc_out  = ~crc;
   assign tx_valid = busy;
   assign tx_last  = busy && (idx == len + LEN_W'(1));

   always_comb begin
      if (idx < len)       tx_data = pbyte;
      else if (idx == len) tx_data = crc_out[7:0];
      else                 tx_data = crc_out[15:8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pay  <= '0;
         len  <= '0;
         idx  <= '0;
         crc  <= 16'hFFFF;
      end else if (load && !busy) begin
         busy <= 1'b1;
         pay  <= ld_bytes;
         len  <= ld_len;
         idx  <= '0;
         crc  <= 16'hFFFF;
      end else if (busy) begin
         if (idx < len) crc <= crcb_step(crc, pbyte);
         if (idx == len + LEN_W'(1)) busy <= 1'b0;
         idx <= idx + LEN_W'(1);
      end
   end

endmodule

// File: rtl/tag_cmd_fsm.sv
module tag_cmd_fsm #(
   parameter logic [7:0]  SEED       = 8'hA7,
   parameter int          UID_W      = 64,
   parameter logic [63:0] TAG_UID    = 64'hE002_3C4D_5A6B_7081,
   parameter int          BLOCKS     = 16,
   parameter int          WORD_W     = 32,
   parameter logic [7:0]  SYS_BLOCK  = 8'hFF,
   parameter logic [31:0] SYS_WORD   = 32'h1F2E_3D4C,
   parameter int          CNT_W      = 4,
   parameter int          MAX_RX     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eof,
   input  logic             rx_crc_ok,
   input  logic             field_lost,
   input  logic             field_ignore,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic [1:0]       tag_state,
   output logic [CNT_W-1:0] reset_count
);
   import tag_pkg::*;

   localparam int UID_BYTES  = UID_W / 8;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int TX_MAX     = (UID_BYTES > WORD_BYTES) ? UID_BYTES : WORD_BYTES;
   localparam int TXL_W      = $clog2(TX_MAX + 2);
   localparam int RXL_W      = $clog2(MAX_RX + 2);

   // elaboration checks
   if (BLOCKS < 1 || BLOCKS > 16) begin : g_bad_blocks
      $error("BLOCKS must be 1..16");
   end
   if ((WORD_W % 8) != 0 || WORD_BYTES > 16 || WORD_W > 32) begin : g_bad_word
      $error("WORD_W must be a byte multiple of at most 32 bits");
   end
   if ((UID_W % 8) != 0 || UID_W > 64) begin : g_bad_uid
      $error("UID_W must be a byte multiple of at most 64 bits");
   end
   if (SEED == 8'h00) begin : g_bad_seed
      $error("SEED must be nonzero");
   end
   if (MAX_RX < 4) begin : g_bad_rx
      $error("MAX_RX must be at least 4");
   end
   if (int'(SYS_BLOCK) < BLOCKS) begin : g_bad_sys
      $error("SYS_BLOCK must lie above the data blocks");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   // block contents: byte k of block b is {b, k} as nibbles
   logic [BLOCKS-1:0][WORD_W-1:0] rom;
   for (genvar gb = 0; gb < BLOCKS; gb++) begin : g_blk
      for (genvar gk = 0; gk < WORD_BYTES; gk++) begin : g_byte
         assign rom[gb][8*gk +: 8] = {4'(gb), 4'(gk)};
      end
   end

   logic             fr_valid, fr_crc_ok;
   logic [RXL_W-1:0] fr_len;
   logic [7:0]       fr_b0, fr_b1;

   tag_rx_frame #(
      .MAX_RX (MAX_RX),
      .LEN_W  (RXL_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_eof    (rx_eof),
      .rx_crc_ok (rx_crc_ok),
      .fr_valid  (fr_valid),
      .fr_crc_ok (fr_crc_ok),
      .fr_len    (fr_len),
      .fr_b0     (fr_b0),
      .fr_b1     (fr_b1)
   );

   tag_state_e        state;
   logic [7:0]        lfsr, chip_id;
   tag_act_e          act;
   logic              addr_ok;
   logic [WORD_W-1:0] rd_word;

   // maximal-length 8-bit LFSR, free running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr <= SEED;
      else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   end

   assign addr_ok = (fr_b1 < 8'(BLOCKS)) || (fr_b1 == SYS_BLOCK);

   always_comb begin
      rd_word = SYS_WORD[WORD_W-1:0];
      for (int i = 0; i < BLOCKS; i++) begin
         if (fr_b1 == 8'(i)) rd_word = rom[i];
      end
   end

   // command decode; field loss takes priority
   always_comb begin
      act = ACT_NONE;
      if (field_lost && !field_ignore) begin
         act = ACT_DROP;
      end else if (fr_valid && fr_crc_ok) begin
         if (fr_len == RXL_W'(4) && fr_b0 == OP_INIT && fr_b1 == INIT_ARG)
            act = ACT_INIT;
         else if (state == ST_INVENTORY && fr_len == RXL_W'(4) &&
                  fr_b0 == OP_SEL && fr_b1 == chip_id)
            act = ACT_SEL;
         else if (state == ST_SELECTED && fr_len == RXL_W'(3) && fr_b0 == OP_UID)
            act = ACT_UID;
         else if (state == ST_SELECTED && fr_len == RXL_W'(4) &&
                  fr_b0 == OP_READ && addr_ok)
            act = ACT_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_READY;
         chip_id     <= '0;
         reset_count <= '0;
      end else begin
         unique case (act)
            ACT_DROP: state <= ST_READY;
            ACT_INIT: begin
               if (state == ST_SELECTED && reset_count != {CNT_W{1'b1}})
                  reset_count <= reset_count + CNT_W'(1);
               state   <= ST_INVENTORY;
               chip_id <= lfsr;
            end
            ACT_SEL:  state <= ST_SELECTED;
            ACT_UID:  reset_count <= '0;
            default: ;
         endcase
      end
   end

   logic                load;
   logic [TXL_W-1:0]    ld_len;
   logic [8*TX_MAX-1:0] ld_bytes;

   always_comb begin
      load     = 1'b0;
      ld_len   = '0;
      ld_bytes = '0;
      unique case (act)
         ACT_INIT: begin
            load          = 1'b1;
            ld_len        = TXL_W'(1);
            ld_bytes[7:0] = lfsr;
         end
         ACT_SEL: begin
            load          = 1'b1;
            ld_len        = TXL_W'(1);
            ld_bytes[7:0] = chip_id;
         end
         ACT_UID: begin
            load                  = 1'b1;
            ld_len                = TXL_W'(UID_BYTES);
            ld_bytes[UID_W-1:0]   = TAG_UID[UID_W-1:0];
         end
         ACT_READ: begin
            load                  = 1'b1;
            ld_len                = TXL_W'(WORD_BYTES);
            ld_bytes[WORD_W-1:0]  = rd_word;
         end
         default: ;
      endcase
   end

   tag_tx_ser #(
      .TX_MAX (TX_MAX),
      .LEN_W  (TXL_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ld_len   (ld_len),
      .ld_bytes (ld_bytes),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_last  (tx_last)
   );

   assign tag_state = state;

endmodule

// File: rtl/tag_cmd_fsm_chk.sv
module tag_cmd_fsm_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             field_lost,
   input logic             field_ignore,
   input logic             tx_valid,
   input logic             tx_last,
   input logic [1:0]       tag_state,
   input logic [CNT_W-1:0] reset_count
);

   // R1: only the three defined state codes appear
   a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      tag_state != 2'd3);

   // R3: SELECTED is entered only from INVENTORY, with the echo starting
   a_r3_enter_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_state == 2'd2 && $past(tag_state) != 2'd2)
      |-> ($past(tag_state) == 2'd1 && tx_valid));

   // R6: the restart counter grows only on a SELECTED to INVENTORY step
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_count != $past(reset_count) && reset_count != '0)
      |-> ($past(tag_state) == 2'd2 && tag_state == 2'd1));

   // R4: the counter clears only while the tag stays selected
   a_r4_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_count != $past(reset_count) && reset_count == '0)
      |-> ($past(tag_state) == 2'd2 && tag_state == 2'd2));

   // R9: an unmasked field loss lands in READY without a new reply
   a_r9_field_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (field_lost && !field_ignore) |=> (tag_state == 2'd0 && !$rose(tx_valid)));

   // R10: the last-byte marker sits inside a response and ends it
   a_r10_last_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r10_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |=> !tx_valid);

endmodule

bind tag_cmd_fsm tag_cmd_fsm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .field_lost   (field_lost),
   .field_ignore (field_ignore),
   .tx_valid     (tx_valid),
   .tx_last      (tx_last),
   .tag_state    (tag_state),
   .reset_count  (reset_count)
);

// File: tb/tag_cmd_fsm_tb.sv
module tag_cmd_fsm_tb;

   localparam logic [63:0] UID_V = 64'hE002_3C4D_5A6B_7081;
   localparam logic [31:0] SYS_V = 32'h1F2E_3D4C;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
   logic       field_lost = 1'b0, field_ignore = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       tx_valid, tx_last;
   logic [7:0] tx_data;
   logic [1:0] tag_state;
   logic [3:0] reset_count;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   logic [7:0] fr [16];
   int         fr_n;
   logic [7:0] rsp [20];
   int         rsp_n, last_pos;
   logic [7:0] exp_b [16];
   int         exp_n;
   logic [7:0] cur_id;
   int         exp_cnt;

   always #10 clk = ~clk;

   tag_cmd_fsm #(.TAG_UID(UID_V), .SYS_WORD(SYS_V)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_eof       (rx_eof),
      .rx_crc_ok    (rx_crc_ok),
      .field_lost   (field_lost),
      .field_ignore (field_ignore),
      .tx_valid     (tx_valid),
      .tx_data      (tx_data),
      .tx_last      (tx_last),
      .tag_state    (tag_state),
      .reset_count  (reset_count)
   );

   // bitwise CRC_B model
   function automatic logic [15:0] ref_crc(input logic [7:0] d [16], input int n);
      logic [15:0] c;
      bit fb;
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         for (int j = 0; j < 8; j++) begin
            fb = c[0] ^ d[i][j];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      end
      return ~c;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic mk(input logic [7:0] a, input logic [7:0] b, input int n);
      logic [15:0] c;
      fr[0] = a;
      fr[1] = b;
      c = ref_crc(fr, n);
      fr[n]     = c[7:0];
      fr[n + 1] = c[15:8];
      fr_n = n + 2;
   endtask

   task automatic xfer(input bit ok);
      for (int i = 0; i < fr_n; i++) begin
         rx_valid = 1'b1;
         rx_data  = fr[i];
         @(negedge clk);
      end
      rx_valid  = 1'b0;
      rx_eof    = 1'b1;
      rx_crc_ok = ok;
      @(negedge clk);
      rx_eof    = 1'b0;
      rx_crc_ok = 1'b0;
      @(negedge clk);
      rsp_n    = 0;
      last_pos = -1;
      while (tx_valid && rsp_n < 20) begin
         rsp[rsp_n] = tx_data;
         if (tx_last) last_pos = rsp_n;
         rsp_n++;
         @(negedge clk);
      end
   endtask

   task automatic expect_reply(input string req);
      logic [15:0] c;
      c = ref_crc(exp_b, exp_n);
      chk(rsp_n == exp_n + 2, req, "reply length (R10)", 64'(rsp_n), 64'(exp_n + 2));
      if (rsp_n == exp_n + 2) begin
         for (int i = 0; i < exp_n; i++)
            chk(rsp[i] == exp_b[i], req, "payload byte", 64'(rsp[i]), 64'(exp_b[i]));
         chk(rsp[exp_n] == c[7:0], req, "CRC low byte (R11)", 64'(rsp[exp_n]), 64'(c[7:0]));
         chk(rsp[exp_n + 1] == c[15:8], req, "CRC high byte (R11)",
             64'(rsp[exp_n + 1]), 64'(c[15:8]));
         chk(last_pos == rsp_n - 1, req, "last marker (R10)", 64'(last_pos), 64'(rsp_n - 1));
      end
   endtask

   task automatic expect_none(input string req);
      chk(rsp_n == 0, req, "no reply", 64'(rsp_n), 64'd0);
   endtask

   task automatic do_init(input string req);
      mk(8'h06, 8'h00, 2);
      xfer(1'b1);
      cur_id   = (rsp_n > 0) ? rsp[0] : 8'h00;
      exp_b[0] = cur_id;
      exp_n    = 1;
      expect_reply(req);
      chk(cur_id != 8'h00, req, "chip ID nonzero", 64'(cur_id), 64'd1);
      chk(tag_state == 2'd1, req, "state after initiate", 64'(tag_state), 64'd1);
   endtask

   task automatic do_select(input string req);
      mk(8'h0E, cur_id, 2);
      xfer(1'b1);
      exp_b[0] = cur_id;
      exp_n    = 1;
      expect_reply(req);
      chk(tag_state == 2'd2, req, "state after select", 64'(tag_state), 64'd2);
   endtask

   task automatic t_reset;
      chk(tag_state == 2'd0, "R1", "state", 64'(tag_state), 64'd0);
      chk(reset_count == 4'd0, "R1", "count", 64'(reset_count), 64'd0);
      chk(tx_valid == 1'b0, "R1", "tx_valid", 64'(tx_valid), 64'd0);
   endtask

   task automatic t_ready_ignores;
      mk(8'h0B, 8'h00, 1);
      xfer(1'b1);
      expect_none("R8");
      chk(tag_state == 2'd0, "R8", "uid in READY keeps state", 64'(tag_state), 64'd0);
      mk(8'h06, 8'h00, 2);
      xfer(1'b0);
      expect_none("R8");
      chk(tag_state == 2'd0, "R8", "bad CRC keeps state", 64'(tag_state), 64'd0);
   endtask

   task automatic t_init_select;
      do_init("R2");
      mk(8'h0E, cur_id ^ 8'h01, 2);
      xfer(1'b1);
      expect_none("R3");
      chk(tag_state == 2'd1, "R3", "wrong ID keeps state", 64'(tag_state), 64'd1);
      do_init("R2");
      do_select("R3");
   endtask

   task automatic t_uid;
      mk(8'h0B, 8'h00, 1);
      xfer(1'b1);
      for (int k = 0; k < 8; k++) exp_b[k] = UID_V[8*k +: 8];
      exp_n = 8;
      expect_reply("R4");
   endtask

   task automatic t_reads;
      for (int b = 0; b < 17; b++) begin
         logic [7:0] a;
         a = (b == 16) ? 8'hFF : 8'(b);
         mk(8'h08, a, 2);
         xfer(1'b1);
         for (int k = 0; k < 4; k++)
            exp_b[k] = (b == 16) ? SYS_V[8*k +: 8] : {a[3:0], 4'(k)};
         exp_n = 4;
         expect_reply("R5");
      end
      mk(8'h08, 8'h10, 2);
      xfer(1'b1);
      expect_none("R5");
      mk(8'h33, 8'h01, 2);
      xfer(1'b1);
      expect_none("R8");
      chk(tag_state == 2'd2, "R8", "unknown opcode keeps state", 64'(tag_state), 64'd2);
   endtask

   task automatic t_restart;
      do_init("R6");
      chk(reset_count == 4'd1, "R6", "count after restart", 64'(reset_count), 64'd1);
      do_select("R6");
      do_init("R6");
      chk(reset_count == 4'd2, "R6", "count after second restart", 64'(reset_count), 64'd2);
      do_select("R6");
      t_uid;
      chk(reset_count == 4'd0, "R4", "count cleared by UID", 64'(reset_count), 64'd0);
   endtask

   task automatic t_trunc;
      fr[0] = 8'h97;
      fr[1] = 8'h5C;
      fr_n  = 2;
      xfer(1'b0);
      expect_none("R7");
      chk(tag_state == 2'd2, "R7", "other 2-byte frame keeps state", 64'(tag_state), 64'd2);
      fr[0] = 8'h97;
      fr[1] = 8'h5B;
      fr_n  = 2;
      xfer(1'b0);
      cur_id   = (rsp_n > 0) ? rsp[0] : 8'h00;
      exp_b[0] = cur_id;
      exp_n    = 1;
      expect_reply("R7");
      chk(tag_state == 2'd1, "R7", "state after rebuilt initiate", 64'(tag_state), 64'd1);
      chk(reset_count == 4'd1, "R7", "rebuilt initiate counts restart", 64'(reset_count), 64'd1);
   endtask

   task automatic t_field;
      do_select("R9");
      field_ignore = 1'b1;
      field_lost   = 1'b1;
      @(negedge clk);
      field_lost   = 1'b0;
      chk(tag_state == 2'd2, "R9", "masked field loss", 64'(tag_state), 64'd2);
      @(negedge clk);
      chk(tx_valid == 1'b0, "R9", "masked field loss reply", 64'(tx_valid), 64'd0);
      field_ignore = 1'b0;
      field_lost   = 1'b1;
      @(negedge clk);
      field_lost   = 1'b0;
      chk(tag_state == 2'd0, "R9", "field loss to READY", 64'(tag_state), 64'd0);
      chk(tx_valid == 1'b0, "R9", "field loss reply", 64'(tx_valid), 64'd0);
      chk(reset_count == 4'd1, "R9", "field loss keeps count", 64'(reset_count), 64'd1);
   endtask

   task automatic t_saturate;
      do_init("R2");
      exp_cnt = 1;
      for (int i = 0; i < 16; i++) begin
         do_select("R6");
         do_init("R6");
         exp_cnt = (exp_cnt < 15) ? exp_cnt + 1 : 15;
      end
      chk(reset_count == 4'(exp_cnt), "R6", "saturated count",
          64'(reset_count), 64'(exp_cnt));
      chk(exp_cnt == 15, "R6", "saturation limit", 64'(exp_cnt), 64'd15);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ready_ignores;
      t_init_select;
      t_uid;
      t_reads;
      t_restart;
      t_trunc;
      t_field;
      t_saturate;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule